// File: doc/BRIEF.md
# Flash Program/Erase Sequencer

This block drives the write procedure of an embedded flash array without software timing loops. A command port takes three kinds of command: a control write that picks the operating mode, a key write used for the unlock handshake, and a start command that carries an address and source data. Writing mode opens only after two key writes in a row. Before any program or erase can start, a fixed high-voltage settling time must pass after that point.

In programming mode each trial drives one timed pulse onto the addressed word, or onto a word pair when the wide bit is set. A verify follows, made of two reads with a fixed gap between them. Both reads must match the source. A bounded trial counter ends the loop with a latched failure flag. In erase mode one of four banks receives one long timed pulse while a busy flag is raised. A supply-valid input is watched during the erase, and a drop latches a fault flag. All delays come from microsecond parameters multiplied by a clock-rate parameter.

Top module: `flash_seq`

## Requirements
- R1: After reset the block is in standard mode: wmode, ready, busy, fail and vpp_fault are all 0. Writing mode opens only when a key command with cmd_data[7:0]=0xA5 is followed immediately by a key command with 0x5A. Any other command between the two cancels the unlock.
- R2: ready rises exactly SETUP_US*CLK_MHZ cycles after the cycle that completes the unlock. A start command issued before ready is ignored.
- R3: A control write (cmd_kind=0) sets the mode: bit0 is write-enable, bit1 is erase-enable, bit2 is the wide select, bits 4:3 are the bank, and bit5 is the exit bit. With {erase,write}=01, a start (cmd_kind=2) raises arr_pgm for PULSE_US*CLK_MHZ cycles. The pulse targets cmd_addr, with the low 16 data bits, or all 32 bits when wide is set.
- R4: After each pulse, arr_rd is high for one cycle. Then VGAP_US*CLK_MHZ idle cycles pass, then arr_rd is high for one more cycle. The trial passes only if both reads equal the source data under the width mask.
- R5: A failed verify starts a new pulse until MAX_TRIALS pulses have been applied. After that, fail is set. fail only ever rises at the end of a verify, and it is cleared when the next program starts.
- R6: With {erase,write}=10, a start raises arr_erase for ERASE_US*CLK_MHZ cycles, with arr_bank holding the bank field captured from the control register.
- R7: busy is high from the cycle after an accepted start until the program or erase sequence completes, and ready is low during that time.
- R8: If vpp_ok is low in any cycle of an erase, vpp_fault is set and stays set until the next erase start.
- R9: A control write with bit5 set while in writing mode leaves writing mode at once. It aborts any running operation and clears busy and ready, but it leaves fail and vpp_fault unchanged.
- R10: A start outside writing mode has no effect. So does a control write without the exit bit while busy. The running operation, its bank and its timing stay as they were.
- R11: A start in mode {erase,write}=00 (standard read) or 11 (verify read) launches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_kind | input | 2 | 0 control, 1 key, 2 start |
| cmd_addr | input | ADDR_W | Target word address for start |
| cmd_data | input | 32 | Control bits, key byte or source data |
| vpp_ok | input | 1 | Programming supply is valid |
| arr_rdata | input | 32 | Array read data {word addr+1, word addr} |
| wmode | output | 1 | Writing mode is open |
| ready | output | 1 | Setup done and idle, start accepted |
| busy | output | 1 | Program or erase sequence running |
| fail | output | 1 | Last program ran out of trials |
| vpp_fault | output | 1 | Supply dropped during the last erase |
| arr_addr | output | ADDR_W | Array word address |
| arr_wdata | output | 32 | Program data |
| arr_wide | output | 1 | Program a word pair |
| arr_bank | output | 2 | Bank to erase |
| arr_pgm | output | 1 | Program pulse active |
| arr_erase | output | 1 | Erase pulse active |
| arr_rd | output | 1 | Verify read strobe |

## Verification
The hardest state to reach is retry exhaustion, because a healthy array passes on the first pulse. The bench's array model therefore stores, for each address, how many pulses a cell needs before it takes the data. Some cells are set to need several pulses and some to need far more than the limit. A second path to exhaustion is a program that asks for a 1 over a bit already at 0, which can never verify. The other hard states are a supply drop and an abort in the middle of an erase. For these, vpp_ok and the exit write are timed from the bench while arr_erase is high, and the untouched bank is read back afterwards.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
    typedef enum logic [2:0] {
        S_OFF, S_SETUP, S_IDLE, S_PULSE, S_RD1, S_GAP, S_RD2, S_ERASE
    } seq_state_t;

    localparam logic [1:0] K_CTRL  = 2'd0;
    localparam logic [1:0] K_KEY   = 2'd1;
    localparam logic [1:0] K_START = 2'd2;

    localparam logic [7:0] KEY_FIRST  = 8'hA5;
    localparam logic [7:0] KEY_SECOND = 8'h5A;

    localparam int B_WREN  = 0;
    localparam int B_EREN  = 1;
    localparam int B_WIDE  = 2;
    localparam int B_BANK  = 3;
    localparam int B_EXIT  = 5;
endpackage

// File: rtl/flash_seq_unlock.sv
module flash_seq_unlock
    import flash_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic       is_key,
    input  logic [7:0] key_byte,
    output logic       opened
);
    logic armed_d, armed_q;

    always_comb begin
        armed_d = armed_q;
        opened  = cmd_valid && is_key && armed_q && (key_byte == KEY_SECOND);
        if (cmd_valid)
            armed_d = is_key && (key_byte == KEY_FIRST);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= armed_d;
    end
endmodule

// File: rtl/flash_seq_timer.sv
module flash_seq_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)             cnt_d = load_val;
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        else                  cnt_d = cnt_q;
        zero = (cnt_q == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/flash_seq.sv
module flash_seq
    import flash_seq_pkg::*;
#(
    parameter int CLK_MHZ    = 20,
    parameter int SETUP_US   = 10,
    parameter int PULSE_US   = 100,
    parameter int VGAP_US    = 4,
    parameter int ERASE_US   = 1000,
    parameter int MAX_TRIALS = 25,
    parameter int ADDR_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_kind,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [31:0]       cmd_data,
    input  logic              vpp_ok,
    input  logic [31:0]       arr_rdata,
    output logic              wmode,
    output logic              ready,
    output logic              busy,
    output logic              fail,
    output logic              vpp_fault,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [31:0]       arr_wdata,
    output logic              arr_wide,
    output logic [1:0]        arr_bank,
    output logic              arr_pgm,
    output logic              arr_erase,
    output logic              arr_rd
);
    localparam int SETUP_CYC = SETUP_US * CLK_MHZ;
    localparam int PULSE_CYC = PULSE_US * CLK_MHZ;
    localparam int VGAP_CYC  = VGAP_US * CLK_MHZ;
    localparam int ERASE_CYC = ERASE_US * CLK_MHZ;
    localparam int MAX_AB    = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
    localparam int MAX_CD    = (VGAP_CYC > ERASE_CYC) ? VGAP_CYC : ERASE_CYC;
    localparam int MAX_CYC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int TW        = $clog2(MAX_CYC + 1);
    localparam int NW        = $clog2(MAX_TRIALS + 1);

    typedef struct packed {
        seq_state_t        st;
        logic              wm;
        logic              wr_en;
        logic              er_en;
        logic              wide;
        logic [1:0]        bank;
        logic [NW-1:0]     trials;
        logic [31:0]       src;
        logic [ADDR_W-1:0] addr;
        logic [31:0]       rd1;
        logic              fail;
        logic              vpp;
    } seq_regs_t;

    seq_regs_t d, q;
    logic          opened, tmr_zero, tmr_load, op_busy, pass, erase_go;
    logic [TW-1:0] tmr_val;
    logic [31:0]   mask;

    flash_seq_unlock u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .is_key   (cmd_kind == K_KEY),
        .key_byte (cmd_data[7:0]),
        .opened   (opened)
    );

    flash_seq_timer #(.W(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .zero    (tmr_zero)
    );

    always_comb begin
        d         = q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        arr_pgm   = 1'b0;
        arr_erase = 1'b0;
        arr_rd    = 1'b0;
        erase_go  = 1'b0;
        op_busy   = (q.st == S_PULSE) || (q.st == S_RD1) || (q.st == S_GAP) ||
                    (q.st == S_RD2) || (q.st == S_ERASE);
        mask      = q.wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        pass      = ((arr_rdata & mask) == (q.src & mask)) &&
                    ((q.rd1 & mask) == (q.src & mask));

        unique case (q.st)
            S_SETUP: if (tmr_zero) d.st = S_IDLE;
            S_PULSE: begin
                arr_pgm = 1'b1;
                if (tmr_zero) d.st = S_RD1;
            end
            S_RD1: begin
                arr_rd   = 1'b1;
                d.rd1    = arr_rdata;
                d.st     = S_GAP;
                tmr_load = 1'b1;
                tmr_val  = TW'(VGAP_CYC - 1);
            end
            S_GAP: if (tmr_zero) d.st = S_RD2;
            S_RD2: begin
                arr_rd = 1'b1;
                if (pass) begin
                    d.st = S_IDLE;
                end else if (q.trials == NW'(1)) begin
                    d.st   = S_IDLE;
                    d.fail = 1'b1;
                end else begin
                    d.trials = q.trials - 1'b1;
                    d.st     = S_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(PULSE_CYC - 1);
                end
            end
            S_ERASE: begin
                arr_erase = 1'b1;
                if (!vpp_ok) d.vpp = 1'b1;
                if (tmr_zero) d.st = S_IDLE;
            end
            default: ;
        endcase

        if (opened && !q.wm) begin
            d.wm     = 1'b1;
            d.st     = S_SETUP;
            tmr_load = 1'b1;
            tmr_val  = TW'(SETUP_CYC - 1);
        end

        if (cmd_valid && cmd_kind == K_CTRL) begin
            if (cmd_data[B_EXIT] && q.wm) begin
                d.wm = 1'b0;
                d.st = S_OFF;
            end else if (!op_busy) begin
                d.wr_en = cmd_data[B_WREN];
                d.er_en = cmd_data[B_EREN];
                d.wide  = cmd_data[B_WIDE];
                d.bank  = cmd_data[B_BANK +: 2];
            end
        end

        if (cmd_valid && cmd_kind == K_START && q.st == S_IDLE) begin
            if (q.wr_en && !q.er_en) begin
                d.st     = S_PULSE;
                d.trials = NW'(MAX_TRIALS);
                d.src    = cmd_data;
                d.addr   = cmd_addr;
                d.fail   = 1'b0;
                tmr_load = 1'b1;
                tmr_val  = TW'(PULSE_CYC - 1);
            end else if (q.er_en && !q.wr_en) begin
                erase_go = 1'b1;
                d.st     = S_ERASE;
                d.vpp    = 1'b0;
                tmr_load = 1'b1;
                tmr_val  = TW'(ERASE_CYC - 1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_OFF;
        end else begin
            q <= d;
        end
    end

    assign wmode     = q.wm;
    assign ready     = (q.st == S_IDLE);
    assign busy      = op_busy;
    assign fail      = q.fail;
    assign vpp_fault = q.vpp;
    assign arr_addr  = q.addr;
    assign arr_wdata = q.src;
    assign arr_wide  = q.wide;
    assign arr_bank  = q.bank;

    // R7, R10: an operation runs only inside writing mode
    a_r10_busy_in_wmode: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> wmode);
    // R2: an operation can only begin from the ready state
    a_r2_start_from_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ready));
    // R3, R4, R6: at most one array strobe at a time
    a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arr_pgm, arr_erase, arr_rd}));
    // R6: bank held for the whole erase
    a_r6_bank_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_erase && $past(arr_erase)) |-> $stable(arr_bank));
    // R5: fail rises only at the end of a verify
    a_r5_fail_from_verify: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> $past(arr_rd));
    // R8: the supply fault holds until a new erase starts
    a_r8_vpp_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (vpp_fault && !erase_go) |=> vpp_fault);
    // R9: exit write closes writing mode and stops the operation
    a_r9_exit_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == K_CTRL && cmd_data[B_EXIT] && wmode)
        |=> (!wmode && !busy && !ready));
endmodule

// File: tb/sim_flash_seq.sv
module sim_flash_seq;
    localparam int TCLK    = 10;
    localparam int MHZ     = 2;
    localparam int SETUP   = 10 * MHZ;
    localparam int PULSE   = 100 * MHZ;
    localparam int VGAP    = 4 * MHZ;
    localparam int ERASE   = 500 * MHZ;
    localparam int TRIALS  = 4;

    logic        clk = 0, rst_n = 0;
    logic        cmd_valid = 0;
    logic [1:0]  cmd_kind = 0;
    logic [7:0]  cmd_addr = 0;
    logic [31:0] cmd_data = 0;
    logic        vpp_ok = 1;
    logic [31:0] arr_rdata;
    logic        wmode, ready, busy, fail, vpp_fault, arr_wide, arr_pgm, arr_erase, arr_rd;
    logic [7:0]  arr_addr;
    logic [31:0] arr_wdata;
    logic [1:0]  arr_bank;

    int checks = 0, errors = 0;

    flash_seq #(.CLK_MHZ(MHZ), .SETUP_US(10), .PULSE_US(100), .VGAP_US(4),
                .ERASE_US(500), .MAX_TRIALS(TRIALS), .ADDR_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .vpp_ok(vpp_ok), .arr_rdata(arr_rdata),
        .wmode(wmode), .ready(ready), .busy(busy), .fail(fail), .vpp_fault(vpp_fault),
        .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_wide(arr_wide), .arr_bank(arr_bank),
        .arr_pgm(arr_pgm), .arr_erase(arr_erase), .arr_rd(arr_rd));

    always #(TCLK/2) clk = ~clk;

    // behavioural array: each cell takes data only after need[] pulses
    logic [15:0] mem [256];
    int need [256];
    int pulses [256];
    int pc = 0, ec = 0;
    assign arr_rdata = {mem[8'(arr_addr + 8'd1)], mem[arr_addr]};

    function automatic logic [31:0] peek(input logic [7:0] a);
        return {mem[8'(a + 8'd1)], mem[a]};
    endfunction

    // reference: phase 0 off,1 settle,2 ready,3 pulse,4 read1,5 gap,6 read2,7 erase
    int r_ph, r_left, r_trials;
    bit r_wm, r_key, r_wr, r_er, r_wide, r_fail, r_vpp;
    logic [1:0]  r_bank;
    logic [31:0] r_src, r_rd1, r_mask;
    logic [7:0]  r_addr;

    always @(posedge clk) begin
        if (!rst_n) begin
            r_ph = 0; r_left = 0; r_trials = 0; r_wm = 0; r_key = 0; r_wr = 0; r_er = 0;
            r_wide = 0; r_fail = 0; r_vpp = 0; r_bank = 0; r_src = 0; r_rd1 = 0; r_addr = 0;
            pc = 0; ec = 0;
        end else begin
            int p0;
            bit w0, opened;
            if (arr_pgm) begin
                pc++;
                if (pc == PULSE) begin
                    pc = 0;
                    pulses[arr_addr]++;
                    if (pulses[arr_addr] >= need[arr_addr]) begin
                        mem[arr_addr] = mem[arr_addr] & arr_wdata[15:0];
                        if (arr_wide)
                            mem[8'(arr_addr + 8'd1)] = mem[8'(arr_addr + 8'd1)] & arr_wdata[31:16];
                    end
                end
            end else pc = 0;
            if (arr_erase) begin
                ec++;
                if (ec == ERASE) begin
                    ec = 0;
                    for (int i = 0; i < 256; i++)
                        if (i / 64 == int'(arr_bank)) mem[i] = 16'hFFFF;
                end
            end else ec = 0;

            p0 = r_ph; w0 = r_wm;
            r_mask = r_wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
            case (r_ph)
                1: begin r_left--; if (r_left == 0) r_ph = 2; end
                3: begin r_left--; if (r_left == 0) r_ph = 4; end
                4: begin r_rd1 = peek(r_addr); r_ph = 5; r_left = VGAP; end
                5: begin r_left--; if (r_left == 0) r_ph = 6; end
                6: begin
                    if (((peek(r_addr) & r_mask) == (r_src & r_mask)) &&
                        ((r_rd1 & r_mask) == (r_src & r_mask))) r_ph = 2;
                    else if (r_trials == 1) begin r_ph = 2; r_fail = 1; end
                    else begin r_trials--; r_ph = 3; r_left = PULSE; end
                end
                7: begin
                    if (!vpp_ok) r_vpp = 1;
                    r_left--; if (r_left == 0) r_ph = 2;
                end
                default: ;
            endcase
            opened = cmd_valid && cmd_kind == 1 && cmd_data[7:0] == 8'h5A && r_key;
            if (cmd_valid) r_key = (cmd_kind == 1) && (cmd_data[7:0] == 8'hA5);
            if (opened && !w0) begin r_wm = 1; r_ph = 1; r_left = SETUP; end
            if (cmd_valid && cmd_kind == 0) begin
                if (cmd_data[5] && w0) begin r_wm = 0; r_ph = 0; end
                else if (p0 < 3) begin
                    r_wr = cmd_data[0]; r_er = cmd_data[1];
                    r_wide = cmd_data[2]; r_bank = cmd_data[4:3];
                end
            end
            if (cmd_valid && cmd_kind == 2 && p0 == 2) begin
                if (r_wr && !r_er) begin
                    r_ph = 3; r_left = PULSE; r_trials = TRIALS;
                    r_src = cmd_data; r_addr = cmd_addr; r_fail = 0;
                end else if (r_er && !r_wr) begin
                    r_ph = 7; r_left = ERASE; r_vpp = 0;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the reference
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R1 wmode", 32'(wmode), 32'(r_wm));
            chk("R2 ready", 32'(ready), 32'(r_ph == 2));
            chk("R7 busy", 32'(busy), 32'(r_ph >= 3));
            chk("R5 fail", 32'(fail), 32'(r_fail));
            chk("R8 vpp_fault", 32'(vpp_fault), 32'(r_vpp));
            chk("R3 arr_pgm", 32'(arr_pgm), 32'(r_ph == 3));
            chk("R4 arr_rd", 32'(arr_rd), 32'(r_ph == 4 || r_ph == 6));
            chk("R6 arr_erase", 32'(arr_erase), 32'(r_ph == 7));
        end
    end

    task automatic send(input logic [1:0] k, input logic [7:0] a, input logic [31:0] dt);
        @(negedge clk);
        cmd_valid = 1; cmd_kind = k; cmd_addr = a; cmd_data = dt;
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic unlock();
        send(2'd1, 8'h0, 32'hA5);
        send(2'd1, 8'h0, 32'h5A);
    endtask

    task automatic wait_idle();
        while (busy || !ready) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin mem[i] = 16'hFFFF; need[i] = 1; pulses[i] = 0; end
        need[9] = 3; need[12] = 99;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset state", {27'd0, wmode, ready, busy, fail, vpp_fault}, 32'd0);

        // R10: start before unlock does nothing
        send(2'd0, 8'h0, 32'h01);
        send(2'd2, 8'h05, 32'h1234);
        repeat (3) @(negedge clk);
        chk("R10 start outside writing mode", {30'd0, busy, arr_pgm}, 32'd0);

        // R1: broken key pair
        send(2'd1, 8'h0, 32'hA5);
        send(2'd0, 8'h0, 32'h01);
        send(2'd1, 8'h0, 32'h5A);
        chk("R1 interrupted unlock", 32'(wmode), 32'd0);

        // R1, R2: proper unlock, early start ignored, settle time
        send(2'd1, 8'h0, 32'hA5);
        @(negedge clk); cmd_valid = 1; cmd_kind = 2'd1; cmd_data = 32'h5A;
        @(negedge clk); cmd_valid = 0;
        chk("R1 unlock opens", 32'(wmode), 32'd1);
        send(2'd2, 8'h05, 32'h1234);
        chk("R2 early start ignored", 32'(busy), 32'd0);
        repeat (SETUP - 4) @(negedge clk);
        chk("R2 still settling", 32'(ready), 32'd0);
        repeat (2) @(negedge clk);
        chk("R2 ready after settle", 32'(ready), 32'd1);

        // R3, R4: single pulse program
        send(2'd2, 8'h05, 32'h1234);
        chk("R7 busy after start", 32'(busy), 32'd1);
        wait_idle();
        chk("R3 narrow program data", 32'(mem[5]), 32'h1234);
        chk("R4 one pulse when verify passes", pulses[5], 1);
        chk("R5 fail clear", 32'(fail), 32'd0);
        send(2'd2, 8'h85, 32'h0F0F);
        wait_idle();
        chk("R3 bank2 word", 32'(mem[8'h85]), 32'h0F0F);

        // R5: retries
        send(2'd2, 8'h09, 32'h00AA);
        wait_idle();
        chk("R5 three trials", pulses[9], 3);
        chk("R5 pass after retries", {31'd0, fail}, 32'd0);
        send(2'd2, 8'h0C, 32'h0000);
        wait_idle();
        chk("R5 trial limit", pulses[12], TRIALS);
        chk("R5 fail set", 32'(fail), 32'd1);

        // R3: wide program clears fail
        send(2'd0, 8'h0, 32'h05);
        send(2'd2, 8'h14, 32'hABCD_5555);
        wait_idle();
        chk("R3 wide low word", 32'(mem[8'h14]), 32'h5555);
        chk("R3 wide high word", 32'(mem[8'h15]), 32'hABCD);
        chk("R5 fail cleared by new program", 32'(fail), 32'd0);

        // R4: 1 over 0 never verifies
        send(2'd0, 8'h0, 32'h01);
        send(2'd2, 8'h05, 32'hFFFF);
        wait_idle();
        chk("R4 mismatch exhausts", pulses[5], 1 + TRIALS);
        chk("R4 fail on mismatch", 32'(fail), 32'd1);

        // R11: other modes launch nothing
        send(2'd0, 8'h0, 32'h00);
        send(2'd2, 8'h06, 32'h0);
        chk("R11 standard mode start", 32'(busy), 32'd0);
        send(2'd0, 8'h0, 32'h03);
        send(2'd2, 8'h06, 32'h0);
        chk("R11 verify mode start", 32'(busy), 32'd0);

        // R6, R8, R10: erase bank 0 with a supply dip and a control write
        send(2'd0, 8'h0, 32'h02);
        send(2'd2, 8'h0, 32'h0);
        chk("R6 erase bank", 32'(arr_bank), 32'd0);
        send(2'd0, 8'h0, 32'h1A);
        chk("R10 bank kept while busy", 32'(arr_bank), 32'd0);
        repeat (50) @(negedge clk);
        vpp_ok = 0;
        repeat (3) @(negedge clk);
        vpp_ok = 1;
        wait_idle();
        chk("R8 fault latched", 32'(vpp_fault), 32'd1);
        chk("R6 bank0 erased", 32'(mem[5]), 32'hFFFF);
        chk("R6 bank2 untouched", 32'(mem[8'h85]), 32'h0F0F);
        chk("R5 fail kept through erase", 32'(fail), 32'd1);

        // R9: abort erase of bank 2
        send(2'd0, 8'h0, 32'h12);
        send(2'd2, 8'h0, 32'h0);
        chk("R8 fault cleared at erase start", 32'(vpp_fault), 32'd0);
        vpp_ok = 0;
        repeat (20) @(negedge clk);
        vpp_ok = 1;
        send(2'd0, 8'h0, 32'h20);
        chk("R9 exit closes", {30'd0, wmode, busy}, 32'd0);
        chk("R9 flags kept", {30'd0, fail, vpp_fault}, 32'd3);
        repeat (ERASE) @(negedge clk);
        chk("R9 aborted erase left data", 32'(mem[8'h85]), 32'h0F0F);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule